// File: doc/BRIEF.md
# Ten-Pin Port Function Multiplexer

This block sets what each of ten port pins does. Two 16-bit control registers hold a 2-bit function code for every pin. One register covers the upper pins 9 and 8. The other covers pins 7 to 0. From these codes, and from the chip operating mode, the block routes each pad. A pad can be general I/O, an input-only alternate function, a driven bus output, or a third alternate function. The pad output value, output enable and every input line to the peripherals are muxed to match.

Only a power-on reset clears the registers. A system reset, such as a manual or watchdog reset, keeps the pin setup in place: it clears only the registered read data and blocks writes while it is held. In single-chip mode the bus/address code falls back to general I/O. Software reads and writes the registers through a single-cycle strobe interface. Read data is registered, so it appears one clock after the read strobe.

Top module: `pinfunc_mux`

## Requirements
- R1: While `por_n` is low, both control registers and `rdata` are 0 at once (asynchronous), so every pin is general I/O.
- R2: While `sys_rst_n` is low, register contents do not change and writes are ignored; `rdata` reads 0 one clock after a low `sys_rst_n` edge.
- R3: The upper register (`addr`=0) stores only bits 3:0. Bits 3:2 set pin 9 and bits 1:0 set pin 8. Bits 15:4 always read 0 and writes to them are ignored.
- R4: The lower register (`addr`=1) stores all 16 bits. Pin n (0..7) uses bits 2n+1:2n.
- R5: A write with `wr_en`=1 updates the register at that clock edge, and the pin outputs show the new code right after the edge.
- R6: Code 00 (general I/O): `pad_out`=`gpio_out`, `pad_oe`=`gpio_oe`, `gpio_in`=`pad_in`, and `alt1_in`=`alt3_in`=0 for that pin.
- R7: Code 01 (input-only alternate; on pin 9 the interrupt request): `pad_oe`=0, `pad_out`=0, `alt1_in`=`pad_in`, and the other inputs read 0.
- R8: Code 10 (bus/address output): `pad_oe`=1, `pad_out`=`alt2_out`, and all inputs read 0. When `single_chip`=1, the pin behaves as code 00.
- R9: Code 11: on pin 9 it is an input-only trigger (`pad_oe`=0, `pad_out`=0, `alt3_in`=`pad_in`). On pins 0..8 it is bidirectional (`pad_out`=`alt3_out`, `pad_oe`=`alt3_oe`, `alt3_in`=`pad_in`). The other inputs read 0.
- R10: A read with `rd_en`=1 loads `rdata` with the addressed register on that edge. `rdata` holds its value when `rd_en`=0.
- R11: A read and a write to the same register in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | Non-power-on system reset, active low |
| single_chip | input | 1 | Operating mode: 1 = single-chip (no external bus) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = upper-pin register, 1 = lower-pin register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| pad_in | input | 10 | Pad input values |
| gpio_out | input | 10 | General I/O output data |
| gpio_oe | input | 10 | General I/O output enables |
| alt2_out | input | 10 | Bus/address output data |
| alt3_out | input | 10 | Third alternate output data |
| alt3_oe | input | 10 | Third alternate output enables |
| pad_out | output | 10 | Pad output values |
| pad_oe | output | 10 | Pad output enables |
| gpio_in | output | 10 | Pad input routed to general I/O |
| alt1_in | output | 10 | Pad input routed to first alternate (interrupt) |
| alt3_in | output | 10 | Pad input routed to third alternate (trigger) |

## Verification
Two pairs of events can land in the same cycle. One is a read and a write to the same register; the bench forces this with strobes on one address and expects the old value in `rdata`. The other is a system reset held while writes arrive; the bench forces it by asserting writes during the reset, then reads back and expects the contents from before the reset. A behavioural model tracks both registers every cycle and is compared against all pin outputs at each falling edge.

// File: rtl/pinfunc_pkg.sv
package pinfunc_pkg;
  localparam int FW = 2;           // bits per pin function code
  localparam logic ADDR_HI = 1'b0; // register for the upper pins
  localparam logic ADDR_LO = 1'b1; // register for the lower pins

  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_SEL1 = 2'b01,
    FN_BUS  = 2'b10,
    FN_SEL3 = 2'b11
  } pin_fn_e;

  // Effective function after the operating-mode override.
  function automatic pin_fn_e resolve_fn(logic [FW-1:0] code, logic single_chip);
    pin_fn_e f;
    f = pin_fn_e'(code);
    if (f == FN_BUS && single_chip) f = FN_GPIO;
    return f;
  endfunction

  // Whether an effective function leaves the pad undriven for certain.
  function automatic logic is_input_only(pin_fn_e f, logic sel3_in_only);
    return (f == FN_SEL1) || (f == FN_SEL3 && sel3_in_only);
  endfunction
endpackage

// File: rtl/pinfunc_regs.sv
module pinfunc_regs
  import pinfunc_pkg::*;
#(
  parameter int DW = 16,
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          sys_rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [HW-1:0] cfg_hi,
  output logic [DW-1:0] cfg_lo,
  output logic          wr_hi_evt,
  output logic          wr_lo_evt
);
  logic [DW-1:0] hi_view;

  assign wr_hi_evt = wr_en && sys_rst_n && (addr == ADDR_HI);
  assign wr_lo_evt = wr_en && sys_rst_n && (addr == ADDR_LO);

  always_comb begin
    hi_view = '0;
    hi_view[HW-1:0] = cfg_hi;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_hi <= '0;
      cfg_lo <= '0;
    end else begin
      if (wr_hi_evt) cfg_hi <= wdata[HW-1:0];
      if (wr_lo_evt) cfg_lo <= wdata;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          rdata <= '0;
    else if (!sys_rst_n) rdata <= '0;
    else if (rd_en)      rdata <= (addr == ADDR_LO) ? cfg_lo : hi_view;
  end
endmodule

// File: rtl/pinfunc_decode.sv
module pinfunc_decode
  import pinfunc_pkg::*;
#(
  parameter int NPINS    = 10,
  parameter int TRIG_PIN = 9
) (
  input  logic [NPINS*FW-1:0] codes,
  input  logic                single_chip,
  output pin_fn_e             fn [NPINS],
  output logic [NPINS-1:0]    in_only_mask,
  output logic [NPINS-1:0]    bus_mask
);
  for (genvar n = 0; n < NPINS; n++) begin : g_dec
    assign fn[n]           = resolve_fn(codes[n*FW +: FW], single_chip);
    assign in_only_mask[n] = is_input_only(fn[n], n == TRIG_PIN);
    assign bus_mask[n]     = (fn[n] == FN_BUS);
  end
endmodule

// File: rtl/pinfunc_pin.sv
module pinfunc_pin
  import pinfunc_pkg::*;
#(
  parameter bit SEL3_IN_ONLY = 1'b0
) (
  input  pin_fn_e fn,
  input  logic    pad_in,
  input  logic    gpio_out,
  input  logic    gpio_oe,
  input  logic    alt2_out,
  input  logic    alt3_out,
  input  logic    alt3_oe,
  output logic    pad_out,
  output logic    pad_oe,
  output logic    gpio_in,
  output logic    alt1_in,
  output logic    alt3_in
);
  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    gpio_in = 1'b0;
    alt1_in = 1'b0;
    alt3_in = 1'b0;
    unique case (fn)
      FN_GPIO: begin
        pad_out = gpio_out;
        pad_oe  = gpio_oe;
        gpio_in = pad_in;
      end
      FN_SEL1: alt1_in = pad_in;
      FN_BUS: begin
        pad_out = alt2_out;
        pad_oe  = 1'b1;
      end
      FN_SEL3: begin
        alt3_in = pad_in;
        if (!SEL3_IN_ONLY) begin
          pad_out = alt3_out;
          pad_oe  = alt3_oe;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pinfunc_mux.sv
module pinfunc_mux
  import pinfunc_pkg::*;
#(
  parameter int DW       = 16,
  parameter int NPINS    = 10,
  parameter int HI_PINS  = 2,
  parameter int TRIG_PIN = 9
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             single_chip,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] gpio_out,
  input  logic [NPINS-1:0] gpio_oe,
  input  logic [NPINS-1:0] alt2_out,
  input  logic [NPINS-1:0] alt3_out,
  input  logic [NPINS-1:0] alt3_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] gpio_in,
  output logic [NPINS-1:0] alt1_in,
  output logic [NPINS-1:0] alt3_in
);
  localparam int HW      = HI_PINS * FW;
  localparam int LO_PINS = NPINS - HI_PINS;
  localparam int LW      = LO_PINS * FW;

  // Named internal events and state for the bound checker.
  logic [HW-1:0]       cfg_hi;
  logic [DW-1:0]       cfg_lo;
  logic                wr_hi_evt;
  logic                wr_lo_evt;
  logic [NPINS*FW-1:0] codes;
  pin_fn_e             fn [NPINS];
  logic [NPINS-1:0]    in_only_mask;
  logic [NPINS-1:0]    bus_mask;

  pinfunc_regs #(.DW(DW), .HW(HW)) u_regs (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .cfg_hi    (cfg_hi),
    .cfg_lo    (cfg_lo),
    .wr_hi_evt (wr_hi_evt),
    .wr_lo_evt (wr_lo_evt)
  );

  assign codes = {cfg_hi, cfg_lo[LW-1:0]};

  pinfunc_decode #(.NPINS(NPINS), .TRIG_PIN(TRIG_PIN)) u_dec (
    .codes        (codes),
    .single_chip  (single_chip),
    .fn           (fn),
    .in_only_mask (in_only_mask),
    .bus_mask     (bus_mask)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    pinfunc_pin #(.SEL3_IN_ONLY(n == TRIG_PIN)) u_pin (
      .fn       (fn[n]),
      .pad_in   (pad_in[n]),
      .gpio_out (gpio_out[n]),
      .gpio_oe  (gpio_oe[n]),
      .alt2_out (alt2_out[n]),
      .alt3_out (alt3_out[n]),
      .alt3_oe  (alt3_oe[n]),
      .pad_out  (pad_out[n]),
      .pad_oe   (pad_oe[n]),
      .gpio_in  (gpio_in[n]),
      .alt1_in  (alt1_in[n]),
      .alt3_in  (alt3_in[n])
    );
  end
endmodule

// File: rtl/pinfunc_mux_chk.sv
module pinfunc_mux_chk #(
  parameter int DW    = 16,
  parameter int NPINS = 10,
  parameter int HW    = 4
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             single_chip,
  input logic             rd_en,
  input logic             addr,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rdata,
  input logic [HW-1:0]    cfg_hi,
  input logic [DW-1:0]    cfg_lo,
  input logic             wr_lo_evt,
  input logic [NPINS-1:0] in_only_mask,
  input logic [NPINS-1:0] bus_mask,
  input logic [NPINS-1:0] pad_oe
);
  // R1
  por_clear_chk: assert property (@(posedge clk)
    !por_n |-> (cfg_hi == '0 && cfg_lo == '0 && rdata == '0));

  // R2
  sys_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |=> ($stable(cfg_hi) && $stable(cfg_lo)));

  // R2
  sys_rdata_chk: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |=> (rdata == '0));

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rd_en && sys_rst_n && addr == 1'b0) |=> (rdata[DW-1:HW] == '0));

  // R5
  lo_write_chk: assert property (@(posedge clk) disable iff (!por_n)
    wr_lo_evt |=> (cfg_lo == $past(wdata)));

  // R7
  in_only_oe_chk: assert property (@(posedge clk) disable iff (!por_n)
    (in_only_mask & pad_oe) == '0);

  // R8
  bus_oe_chk: assert property (@(posedge clk) disable iff (!por_n)
    (bus_mask & ~pad_oe) == '0);

  // R8
  single_chip_chk: assert property (@(posedge clk) disable iff (!por_n)
    single_chip |-> (bus_mask == '0));

  // R11
  rd_wr_same_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_lo_evt && rd_en && addr == 1'b1) |=> (rdata == $past(cfg_lo)));
endmodule

bind pinfunc_mux pinfunc_mux_chk #(.DW(DW), .NPINS(NPINS), .HW(HW)) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .sys_rst_n    (sys_rst_n),
  .single_chip  (single_chip),
  .rd_en        (rd_en),
  .addr         (addr),
  .wdata        (wdata),
  .rdata        (rdata),
  .cfg_hi       (cfg_hi),
  .cfg_lo       (cfg_lo),
  .wr_lo_evt    (wr_lo_evt),
  .in_only_mask (in_only_mask),
  .bus_mask     (bus_mask),
  .pad_oe       (pad_oe)
);

// File: tb/pinfunc_mux_tb.sv
module pinfunc_mux_tb_top;
  logic        clk = 1'b0;
  logic        por_n, sys_rst_n, single_chip, wr_en, rd_en, addr;
  logic [15:0] wdata, rdata;
  logic [9:0]  pad_in, gpio_out, gpio_oe, alt2_out, alt3_out, alt3_oe;
  logic [9:0]  pad_out, pad_oe, gpio_in, alt1_in, alt3_in;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural model state
  int unsigned m_hi = 0;
  int unsigned m_lo = 0;
  int unsigned m_rd = 0;
  bit          wrote = 0;

  always #10 clk = ~clk; // 50 MHz

  pinfunc_mux dut_i (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .single_chip(single_chip),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pad_in(pad_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .alt2_out(alt2_out),
    .alt3_out(alt3_out), .alt3_oe(alt3_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .gpio_in(gpio_in), .alt1_in(alt1_in), .alt3_in(alt3_in)
  );

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string rd_tag);
    check({rd_tag, " rdata"}, rdata, m_rd);
    for (int n = 0; n < 10; n++) begin
      int unsigned code, ex;
      string tag;
      code = (n >= 8) ? ((m_hi >> (2 * (n - 8))) & 3) : ((m_lo >> (2 * n)) & 3);
      if (code == 2 && single_chip) begin
        code = 0;
        tag = "R8 single-chip";
      end else begin
        case (code)
          0: tag = "R6";
          1: tag = "R7";
          2: tag = "R8";
          default: tag = "R9";
        endcase
      end
      // expected {pad_out, pad_oe, gpio_in, alt1_in, alt3_in}
      case (code)
        0: ex = {gpio_out[n], gpio_oe[n], pad_in[n], 2'b00};
        1: ex = {4'b0000, pad_in[n]} << 1;
        2: ex = {alt2_out[n], 1'b1, 3'b000};
        default: ex = (n == 9) ? {4'b0000, pad_in[n]}
                               : {alt3_out[n], alt3_oe[n], 2'b00, pad_in[n]};
      endcase
      if (wrote) tag = {"R5+", tag};
      check($sformatf("%s pin%0d", tag, n),
            {pad_out[n], pad_oe[n], gpio_in[n], alt1_in[n], alt3_in[n]}, ex);
    end
  endtask

  task automatic rand_pins();
    pad_in   = 10'($urandom);
    gpio_out = 10'($urandom);
    gpio_oe  = 10'($urandom);
    alt2_out = 10'($urandom);
    alt3_out = 10'($urandom);
    alt3_oe  = 10'($urandom);
  endtask

  // One clock: model update at the edge, compare at the falling edge.
  task automatic step(input string rd_tag);
    @(posedge clk);
    wrote = 0;
    if (!por_n) begin
      m_hi = 0; m_lo = 0; m_rd = 0;
    end else begin
      if (!sys_rst_n)  m_rd = 0;
      else if (rd_en)  m_rd = addr ? m_lo : m_hi;
      if (wr_en && sys_rst_n) begin
        if (addr) m_lo = wdata;
        else      m_hi = wdata & 16'h000F;
        wrote = 1;
      end
    end
    @(negedge clk);
    check_all(rd_tag);
    rand_pins();
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0;
  endtask

  task automatic do_write(input logic a, input logic [15:0] d, input string tag);
    wr_en = 1; rd_en = 0; addr = a; wdata = d;
    step(tag);
    idle();
  endtask

  task automatic do_read(input logic a, input string tag);
    wr_en = 0; rd_en = 1; addr = a;
    step(tag);
    idle();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    por_n = 1; sys_rst_n = 1; single_chip = 0; wr_en = 0; rd_en = 0;
    addr = 0; wdata = 0;
    rand_pins();
    #5 por_n = 0;
    repeat (3) step("R1");
    por_n = 1;
    // R1: reset state of both registers
    do_read(1'b0, "R1");
    do_read(1'b1, "R1");
    // R3: reserved bits of the upper register
    do_write(1'b0, 16'hFFFF, "R3");
    do_read(1'b0, "R3");
    // R4: all bits of the lower register
    do_write(1'b1, 16'hA5C3, "R4");
    do_read(1'b1, "R4");
    do_write(1'b1, 16'hFFFF, "R4");
    do_read(1'b1, "R4");
    // R8: single-chip override of the bus code
    do_write(1'b0, 16'h000A, "R8");
    do_write(1'b1, 16'hAAAA, "R8");
    single_chip = 1;
    step("R8");
    single_chip = 0;
    step("R8");
    // R9: code 11 on every pin
    do_write(1'b0, 16'h000F, "R9");
    do_write(1'b1, 16'hFFFF, "R9");
    repeat (3) step("R9");
    // R11: read and write of the same register together
    wr_en = 1; rd_en = 1; addr = 1; wdata = 16'h1234;
    step("R11");
    wr_en = 1; rd_en = 1; addr = 0; wdata = 16'h0005;
    step("R11");
    idle();
    do_read(1'b1, "R11");
    // R2: system reset with writes attempted
    sys_rst_n = 0;
    wr_en = 1; addr = 1; wdata = 16'h0F0F;
    step("R2");
    wr_en = 1; addr = 0; wdata = 16'h0003;
    rd_en = 1;
    step("R2");
    idle();
    sys_rst_n = 1;
    do_read(1'b1, "R2");
    do_read(1'b0, "R2");
    // R10: random traffic
    for (int i = 0; i < 400; i++) begin
      wr_en = 1'($urandom);
      rd_en = 1'($urandom);
      addr  = 1'($urandom);
      wdata = 16'($urandom);
      single_chip = ($urandom % 4) == 0;
      sys_rst_n   = ($urandom % 16) != 0;
      step("R10");
    end
    idle();
    sys_rst_n = 1;
    // R1: power-on reset in mid-run, asynchronous
    #3 por_n = 0;
    #1 m_hi = 0; m_lo = 0; m_rd = 0; wrote = 0;
    check_all("R1");
    @(negedge clk);
    por_n = 1;
    do_read(1'b1, "R1");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule